// File: doc/BRIEF.md
# Indirect Data Address Generator

This block sits between a processor core and its data register file and forms the address of every data access. An instruction normally names a location with a short offset field, and the current bank selection supplies the upper address bits. One offset in every bank is reserved as a virtual register with no storage behind it. Any access that names this offset is redirected: the address is instead built from a pointer register, with a separate indirect bank bit placed above it.

Software walks through memory by loading the pointer, accessing the virtual register and then incrementing the pointer. When the pointer itself lands on the virtual register's offset, the access refers back to itself. A read then returns zero and a write is dropped. The core may still update its own flags for such a write, because the flags are outside this block. The block is purely combinational. It passes read data from the register file through to the core, or replaces it with zero.

Top module: `ind_addr_gen`

## Requirements
- R1: When the direct offset is not the virtual register offset (0x00), the effective address is the bank bits placed above the 7-bit direct offset: `{bank_i, dir_ofs_i}`.
- R2: When the direct offset is 0x00, the effective address is the indirect bank bit placed above the 8-bit pointer: `{ind_bank_i, ptr_i}`.
- R3: During an indirect access, the bank bits have no effect on the effective address.
- R4: During a direct access, the pointer and the indirect bank bit have no effect on the effective address.
- R5: Outside a self-referencing access, the write enable to the register file equals the core's write strobe.
- R6: A self-referencing access is an indirect access whose pointer low 7 bits equal 0x00. For such an access the register file write enable is 0, whatever the write strobe.
- R7: A self-referencing read returns 0x00, whatever the register file supplies.
- R8: Any other access with the read strobe high returns the register file read data unchanged.
- R9: With the read strobe low, the read data output is 0x00.
- R10: Pointer bit 7 is an address bit. Stepping the pointer from 0x7F to 0x80 moves the effective address from 0x07F to 0x080, and with the indirect bank bit set, from 0x17F to 0x180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_ofs_i | input | 7 | Direct offset field from the instruction |
| bank_i | input | 2 | Bank selection bits for direct accesses |
| ptr_i | input | 8 | Pointer register value |
| ind_bank_i | input | 1 | Bank bit for indirect accesses |
| rd_i | input | 1 | Read strobe from the core |
| wr_i | input | 1 | Write strobe from the core |
| rf_rdata_i | input | 8 | Read data from the register file |
| eff_addr_o | output | 9 | Effective data memory address |
| rf_we_o | output | 1 | Gated write enable to the register file |
| rdata_o | output | 8 | Read data returned to the core |

## Verification
On every evaluation, the assertions check that a self-referencing access never produces a write enable or non-zero read data. They also check that a write enable never appears without a write strobe, that a redirected address carries the indirect bank bit, and that a direct address never lands on the virtual offset. Only the bench scenarios can show the rest. These are exact address composition, the independence of each path from the other path's inputs, the pass-through of data, and the bank carry when the pointer crosses from 0x7F to 0x80. They are covered by comparing random and directed inputs against reference functions.

// File: rtl/ind_addr_pkg.sv
package ind_addr_pkg;
   typedef enum logic [1:0] {
      ACC_DIRECT = 2'd0,
      ACC_REDIR  = 2'd1,
      ACC_SELF   = 2'd2
   } acc_kind_t;
endpackage

// File: rtl/ind_addr_mux.sv
module ind_addr_mux
   import ind_addr_pkg::*;
#(
   parameter int OFS_W    = 7,
   parameter int BANK_W   = 2,
   parameter int PTR_W    = 8,
   parameter int VREG_OFS = 0,
   localparam int ADDR_W  = OFS_W + BANK_W
) (
   input  logic [OFS_W-1:0]  dir_ofs_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic              ind_bank_i,
   output logic [ADDR_W-1:0] eff_addr_o,
   output acc_kind_t         kind_o
);
   localparam logic [OFS_W-1:0] VREG = OFS_W'(VREG_OFS);

   logic              redirect;
   logic [ADDR_W-1:0] dir_addr;
   logic [ADDR_W-1:0] ind_addr;

   assign redirect = (dir_ofs_i == VREG);
   assign dir_addr = {bank_i, dir_ofs_i};
   assign ind_addr = {ind_bank_i, ptr_i};

   always_comb begin
      eff_addr_o = redirect ? ind_addr : dir_addr;
      if (!redirect)
         kind_o = ACC_DIRECT;
      else if (ptr_i[OFS_W-1:0] == VREG)
         kind_o = ACC_SELF;
      else
         kind_o = ACC_REDIR;
   end

   always_comb begin
      // R1
      dir_not_vreg_chk: assert (kind_o != ACC_DIRECT || eff_addr_o[OFS_W-1:0] != VREG);
      // R2
      redir_bank_chk: assert (kind_o == ACC_DIRECT || eff_addr_o[ADDR_W-1] == ind_bank_i);
   end
endmodule

// File: rtl/ind_self_gate.sv
module ind_self_gate
   import ind_addr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  acc_kind_t         kind_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              rf_we_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic self_ref;

   assign self_ref = (kind_i == ACC_SELF);
   assign rf_we_o  = wr_i & ~self_ref;
   assign rdata_o  = (rd_i && !self_ref) ? rf_rdata_i : '0;

   always_comb begin
      // R5
      we_needs_strobe_chk: assert (!rf_we_o || wr_i);
      // R9
      idle_read_zero_chk: assert (rd_i || rdata_o == '0);
   end
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen
   import ind_addr_pkg::*;
#(
   parameter int OFS_W    = 7,
   parameter int BANK_W   = 2,
   parameter int PTR_W    = 8,
   parameter int DATA_W   = 8,
   parameter int VREG_OFS = 0,
   localparam int ADDR_W  = OFS_W + BANK_W
) (
   input  logic [OFS_W-1:0]  dir_ofs_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic              ind_bank_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic [ADDR_W-1:0] eff_addr_o,
   output logic              rf_we_o,
   output logic [DATA_W-1:0] rdata_o
);
   generate
      if (PTR_W + 1 != ADDR_W) begin : g_bad_ptr_w
         $error("pointer width plus one must equal the address width");
      end
      if (VREG_OFS < 0 || VREG_OFS >= (1 << OFS_W)) begin : g_bad_vreg
         $error("virtual register offset outside the direct field");
      end
      if (BANK_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("bank and data widths must be positive");
      end
   endgenerate

   acc_kind_t kind;

   ind_addr_mux #(
      .OFS_W    (OFS_W),
      .BANK_W   (BANK_W),
      .PTR_W    (PTR_W),
      .VREG_OFS (VREG_OFS)
   ) u_mux (
      .dir_ofs_i  (dir_ofs_i),
      .bank_i     (bank_i),
      .ptr_i      (ptr_i),
      .ind_bank_i (ind_bank_i),
      .eff_addr_o (eff_addr_o),
      .kind_o     (kind)
   );

   ind_self_gate #(
      .DATA_W (DATA_W)
   ) u_gate (
      .kind_i     (kind),
      .rd_i       (rd_i),
      .wr_i       (wr_i),
      .rf_rdata_i (rf_rdata_i),
      .rf_we_o    (rf_we_o),
      .rdata_o    (rdata_o)
   );

   always_comb begin
      // R6
      self_no_write_chk: assert (kind != ACC_SELF || !rf_we_o);
      // R7
      self_read_zero_chk: assert (kind != ACC_SELF || rdata_o == '0);
   end
endmodule

// File: tb/ind_addr_gen_bench.sv
module ind_addr_gen_bench;
   logic       clk = 1'b0;
   logic [6:0] dir_ofs;
   logic [1:0] bank;
   logic [7:0] ptr;
   logic       ind_bank, rd, wr;
   logic [7:0] rf_rdata;
   logic [8:0] eff_addr;
   logic       rf_we;
   logic [7:0] rdata;
   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   ind_addr_gen u_ind_addr_gen (
      .dir_ofs_i  (dir_ofs),
      .bank_i     (bank),
      .ptr_i      (ptr),
      .ind_bank_i (ind_bank),
      .rd_i       (rd),
      .wr_i       (wr),
      .rf_rdata_i (rf_rdata),
      .eff_addr_o (eff_addr),
      .rf_we_o    (rf_we),
      .rdata_o    (rdata)
   );

   function automatic logic [8:0] ref_addr(input logic [6:0] d, input logic [1:0] b,
                                           input logic [7:0] p, input logic ib);
      return (d == 7'h00) ? {ib, p} : {b, d};
   endfunction

   function automatic logic ref_self(input logic [6:0] d, input logic [7:0] p);
      return (d == 7'h00) && (p[6:0] == 7'h00);
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [6:0] d, input logic [1:0] b, input logic [7:0] p,
                        input logic ib, input logic r, input logic w, input logic [7:0] rf);
      @(negedge clk);
      dir_ofs = d; bank = b; ptr = p; ind_bank = ib; rd = r; wr = w; rf_rdata = rf;
      @(posedge clk);
      #2;
   endtask

   task automatic full_check;
      logic s;
      s = ref_self(dir_ofs, ptr);
      chk((dir_ofs == 0) ? "R2 addr" : "R1 addr", 16'(eff_addr),
          16'(ref_addr(dir_ofs, bank, ptr, ind_bank)));
      chk(s ? "R6 we" : "R5 we", 16'(rf_we), 16'(wr & ~s));
      if (!rd)     chk("R9 rdata", 16'(rdata), 16'h0);
      else if (s)  chk("R7 rdata", 16'(rdata), 16'h0);
      else         chk("R8 rdata", 16'(rdata), 16'(rf_rdata));
   endtask

   initial begin
      logic [8:0] a0;
      void'($urandom(32'h5EED_1234));
      // all inputs zero: self reference at address 0
      drive(7'h00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R2 zero-input addr", 16'(eff_addr), 16'h000);
      chk("R6 zero-input we", 16'(rf_we), 16'h0);
      chk("R9 zero-input rdata", 16'(rdata), 16'h0);
      // self reference with both strobes high and busy read data
      drive(7'h00, 2'b11, 8'h80, 1'b1, 1'b1, 1'b1, 8'hA5);
      chk("R2 self addr", 16'(eff_addr), 16'h180);
      chk("R6 self write", 16'(rf_we), 16'h0);
      chk("R7 self read", 16'(rdata), 16'h0);
      // R3: bank bits do not move an indirect address
      drive(7'h00, 2'b00, 8'h35, 1'b1, 1'b1, 1'b1, 8'h3C);
      a0 = eff_addr;
      full_check();
      for (int b = 1; b < 4; b++) begin
         drive(7'h00, 2'(b), 8'h35, 1'b1, 1'b1, 1'b1, 8'h3C);
         chk("R3 bank ignored", 16'(eff_addr), 16'(a0));
      end
      // R4: pointer and indirect bank do not move a direct address
      drive(7'h21, 2'b10, 8'h00, 1'b0, 1'b1, 1'b0, 8'h77);
      a0 = eff_addr;
      full_check();
      drive(7'h21, 2'b10, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h77);
      chk("R4 pointer ignored", 16'(eff_addr), 16'(a0));
      chk("R4 direct addr", 16'(eff_addr), 16'h121);
      // R10: pointer stepping across bit 7
      drive(7'h00, 2'b00, 8'h7F, 1'b0, 1'b0, 1'b1, 8'h00);
      chk("R10 before step", 16'(eff_addr), 16'h07F);
      chk("R5 redirected write", 16'(rf_we), 16'h1);
      drive(7'h00, 2'b00, 8'h80, 1'b0, 1'b0, 1'b1, 8'h00);
      chk("R10 after step", 16'(eff_addr), 16'h080);
      chk("R6 pointer 0x80 self", 16'(rf_we), 16'h0);
      drive(7'h00, 2'b01, 8'h7F, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R10 high before", 16'(eff_addr), 16'h17F);
      drive(7'h00, 2'b01, 8'h81, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R10 high after", 16'(eff_addr), 16'h181);
      // constrained random, biased toward redirected and self accesses
      for (int i = 0; i < 600; i++) begin
         logic [6:0] d;
         logic [7:0] p;
         d = ($urandom % 3 == 0) ? 7'h00 : 7'($urandom);
         p = ($urandom % 4 == 0) ? {1'($urandom), 7'h00} : 8'($urandom);
         drive(d, 2'($urandom), p, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
         full_check();
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule